// File: doc/BRIEF.md
# Product-Term Sum Stage with Selectable XOR Polarity

This block is the combinational logic stage of a programmable logic cell. It receives five product terms, each already formed as an AND over selected bus signals, and a sum arriving from a neighbouring cell. A per-term allocation mask decides which terms enter the OR gate. The cascade-in sum can be merged into the OR result when the cascade enable is set. That OR result leaves the cell unchanged as the cascade output, so cells can be chained to build wide sums.

The same OR result then goes into an XOR gate. Its second input is chosen by a polarity select code: constant 0 passes the sum through, constant 1 inverts it, and a product term picked by index is used for toggle-style or compare functions. The cell also drives a foldback signal. This is the inverse of one product term picked by a second index, and it is meant to be shared across a region of four cells. All configuration arrives as static input vectors. The block holds no state.

Top module: `mc_pterm_sum`

## Requirements
- R1: `cas_out_o` is 1 exactly when at least one product term whose `alloc_mask_i` bit is 1 is high, or when cascade is enabled and `cas_in_i` is high. Terms with a mask bit of 0 contribute 0.
- R2: When `cas_en_i` is 0, `cas_in_i` has no effect on any output. When `cas_en_i` is 1 and `cas_in_i` is 1, `cas_out_o` is 1.
- R3: `cas_out_o` is taken ahead of the XOR. It does not depend on `pol_sel_i` or `xor_idx_i`.
- R4: With `pol_sel_i` = 2'b00 (constant 0), `sum_o` equals `cas_out_o`.
- R5: With `pol_sel_i` = 2'b01 (constant 1), `sum_o` is the inverse of `cas_out_o`.
- R6: With `pol_sel_i` = 2'b10 (term), `sum_o` equals `cas_out_o` XOR `pterm_i[xor_idx_i]`.
- R7: The code `pol_sel_i` = 2'b11 is reserved and behaves like 2'b00.
- R8: `fold_o` equals the inverse of `pterm_i[fold_idx_i]`, whether or not that term is allocated to the sum.
- R9: An index of 5 or more selects constant 0. So `fold_o` is 1, and in term mode the XOR input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pterm_i | input | 5 | Product terms; bit i is term i |
| cas_in_i | input | 1 | Sum arriving from the neighbouring cell |
| alloc_mask_i | input | 5 | Bit i routes term i into the OR gate |
| cas_en_i | input | 1 | Merges cas_in_i into the local sum |
| pol_sel_i | input | 2 | Second XOR input: 00 zero, 01 one, 10 term, 11 reserved (zero) |
| xor_idx_i | input | 3 | Term index used when pol_sel_i is 10 |
| fold_idx_i | input | 3 | Term index whose inverse drives fold_o |
| sum_o | output | 1 | XOR result |
| cas_out_o | output | 1 | Local OR sum, before the XOR, for the next cell |
| fold_o | output | 1 | Inverted selected term for the region |

## Verification
Every result (the sum, the cascade output and the foldback) is purely combinational. Each one is due in the same cycle as the input change that causes it, after zero clock edges. The bench changes the inputs on the falling clock edge and reads the outputs one nanosecond later. Each reading is therefore settled and well clear of the rising edge. Table vectors and the directed sweeps of select codes and indices all follow this same drive-then-sample step.

// File: rtl/mc_pterm_pkg.sv
package mc_pterm_pkg;

  // Second XOR operand selection; code 3 is reserved and acts as zero.
  typedef enum logic [1:0] {
    POL_ZERO = 2'b00,
    POL_ONE  = 2'b01,
    POL_TERM = 2'b10,
    POL_RSVD = 2'b11
  } pol_sel_e;

endpackage

// File: rtl/mc_term_pick.sv
module mc_term_pick #(
  parameter int unsigned N_TERMS = 5,
  localparam int unsigned IDX_W  = (N_TERMS > 1) ? $clog2(N_TERMS) : 1
) (
  input  logic [N_TERMS-1:0] terms_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               bit_o
);

  // Index beyond the last term yields constant 0.
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < N_TERMS; i++) begin
      if (idx_i == IDX_W'(i)) bit_o = terms_i[i];
    end
  end

endmodule

// File: rtl/mc_term_sum.sv
module mc_term_sum #(
  parameter int unsigned N_TERMS = 5
) (
  input  logic [N_TERMS-1:0] terms_i,
  input  logic [N_TERMS-1:0] mask_i,
  input  logic               cas_in_i,
  input  logic               cas_en_i,
  output logic               sum_o
);

  logic [N_TERMS-1:0] gated;

  for (genvar g = 0; g < N_TERMS; g++) begin : g_gate
    assign gated[g] = terms_i[g] & mask_i[g];
  end

  assign sum_o = (|gated) | (cas_en_i & cas_in_i);

endmodule

// File: rtl/mc_xor_stage.sv
module mc_xor_stage
  import mc_pterm_pkg::*;
(
  input  logic [1:0] pol_sel_i,
  input  logic       sum_i,
  input  logic       term_i,
  output logic       out_o
);

  logic operand;

  always_comb begin
    unique case (pol_sel_e'(pol_sel_i))
      POL_ONE:  operand = 1'b1;
      POL_TERM: operand = term_i;
      default:  operand = 1'b0;
    endcase
  end

  assign out_o = sum_i ^ operand;

endmodule

// File: rtl/mc_pterm_sum.sv
module mc_pterm_sum #(
  parameter int unsigned N_TERMS = 5,
  localparam int unsigned IDX_W  = (N_TERMS > 1) ? $clog2(N_TERMS) : 1
) (
  input  logic [N_TERMS-1:0] pterm_i,
  input  logic               cas_in_i,
  input  logic [N_TERMS-1:0] alloc_mask_i,
  input  logic               cas_en_i,
  input  logic [1:0]         pol_sel_i,
  input  logic [IDX_W-1:0]   xor_idx_i,
  input  logic [IDX_W-1:0]   fold_idx_i,
  output logic               sum_o,
  output logic               cas_out_o,
  output logic               fold_o
);

  logic or_sum;
  logic xor_term;
  logic fold_term;

  mc_term_sum #(.N_TERMS(N_TERMS)) u_sum (
    .terms_i  (pterm_i),
    .mask_i   (alloc_mask_i),
    .cas_in_i (cas_in_i),
    .cas_en_i (cas_en_i),
    .sum_o    (or_sum)
  );

  mc_term_pick #(.N_TERMS(N_TERMS)) u_xor_pick (
    .terms_i (pterm_i),
    .idx_i   (xor_idx_i),
    .bit_o   (xor_term)
  );

  mc_term_pick #(.N_TERMS(N_TERMS)) u_fold_pick (
    .terms_i (pterm_i),
    .idx_i   (fold_idx_i),
    .bit_o   (fold_term)
  );

  mc_xor_stage u_xor (
    .pol_sel_i (pol_sel_i),
    .sum_i     (or_sum),
    .term_i    (xor_term),
    .out_o     (sum_o)
  );

  assign cas_out_o = or_sum;
  assign fold_o    = ~fold_term;

endmodule

// File: rtl/mc_pterm_sum_chk.sv
module mc_pterm_sum_chk #(
  parameter int unsigned N_TERMS = 5,
  localparam int unsigned IDX_W  = (N_TERMS > 1) ? $clog2(N_TERMS) : 1
) (
  input logic [N_TERMS-1:0] pterm_i,
  input logic               cas_in_i,
  input logic [N_TERMS-1:0] alloc_mask_i,
  input logic               cas_en_i,
  input logic [1:0]         pol_sel_i,
  input logic [IDX_W-1:0]   xor_idx_i,
  input logic [IDX_W-1:0]   fold_idx_i,
  input logic               sum_o,
  input logic               cas_out_o,
  input logic               fold_o
);

  logic known;
  assign known = !$isunknown({pterm_i, cas_in_i, alloc_mask_i, cas_en_i, pol_sel_i,
                              xor_idx_i, fold_idx_i, sum_o, cas_out_o, fold_o});

  always_comb begin
    if (known) begin
      if (|(pterm_i & alloc_mask_i))
        p_alloc_hit_r1: assert (cas_out_o);
      if (alloc_mask_i == '0 && !cas_en_i)
        p_empty_sum_r1: assert (!cas_out_o);
      if (cas_en_i && cas_in_i)
        p_cas_merge_r2: assert (cas_out_o);
      if (pol_sel_i == 2'b00)
        p_pass_r4: assert (sum_o == cas_out_o);
      if (pol_sel_i == 2'b01)
        p_invert_r5: assert (sum_o != cas_out_o);
      if (pol_sel_i == 2'b11)
        p_reserved_r7: assert (sum_o == cas_out_o);
      if (int'(fold_idx_i) >= int'(N_TERMS))
        p_fold_range_r9: assert (fold_o);
      if (pol_sel_i == 2'b10 && int'(xor_idx_i) >= int'(N_TERMS))
        p_xor_range_r9: assert (sum_o == cas_out_o);
    end
  end

endmodule

bind mc_pterm_sum mc_pterm_sum_chk #(.N_TERMS(N_TERMS)) u_chk (
  .pterm_i      (pterm_i),
  .cas_in_i     (cas_in_i),
  .alloc_mask_i (alloc_mask_i),
  .cas_en_i     (cas_en_i),
  .pol_sel_i    (pol_sel_i),
  .xor_idx_i    (xor_idx_i),
  .fold_idx_i   (fold_idx_i),
  .sum_o        (sum_o),
  .cas_out_o    (cas_out_o),
  .fold_o       (fold_o)
);

// File: tb/mc_pterm_sum_tb_top.sv
module mc_pterm_sum_tb_top;

  localparam int NV = 12;
  // {pterm[5], mask[5], cas_en, cas_in, pol[2], xidx[3], fidx[3], exp_sum, exp_cas, exp_fold}
  localparam logic [22:0] VEC [NV] = '{
    {5'b10101, 5'b00000, 1'b0, 1'b1, 2'b00, 3'd0, 3'd0, 3'b000}, // R1 R2
    {5'b10101, 5'b01010, 1'b0, 1'b0, 2'b00, 3'd0, 3'd1, 3'b001}, // R1
    {5'b10101, 5'b00100, 1'b0, 1'b0, 2'b00, 3'd0, 3'd2, 3'b110}, // R1 R8
    {5'b00000, 5'b11111, 1'b1, 1'b1, 2'b00, 3'd0, 3'd3, 3'b111}, // R2
    {5'b00000, 5'b11111, 1'b0, 1'b1, 2'b01, 3'd0, 3'd4, 3'b101}, // R2 R5
    {5'b01000, 5'b01000, 1'b0, 1'b0, 2'b01, 3'd0, 3'd3, 3'b010}, // R5 R8
    {5'b10011, 5'b00011, 1'b0, 1'b0, 2'b10, 3'd4, 3'd0, 3'b010}, // R6
    {5'b10011, 5'b00000, 1'b0, 1'b0, 2'b10, 3'd4, 3'd5, 3'b101}, // R6 R9
    {5'b11111, 5'b00001, 1'b0, 1'b0, 2'b10, 3'd6, 3'd7, 3'b111}, // R9
    {5'b00010, 5'b00010, 1'b0, 1'b0, 2'b11, 3'd1, 3'd1, 3'b110}, // R7
    {5'b00000, 5'b00000, 1'b1, 1'b1, 2'b11, 3'd0, 3'd2, 3'b111}, // R7 R2
    {5'b10000, 5'b10000, 1'b0, 1'b0, 2'b10, 3'd1, 3'd4, 3'b110}  // R6 R8
  };

  logic       clk;
  logic       rst_n;
  logic [4:0] pterm, mask;
  logic       cas_in, cas_en;
  logic [1:0] pol;
  logic [2:0] xidx, fidx;
  logic       sum_o, cas_o, fold_o;
  int         n_vec, n_bad;

  mc_pterm_sum dut_i (
    .pterm_i      (pterm),
    .cas_in_i     (cas_in),
    .alloc_mask_i (mask),
    .cas_en_i     (cas_en),
    .pol_sel_i    (pol),
    .xor_idx_i    (xidx),
    .fold_idx_i   (fidx),
    .sum_o        (sum_o),
    .cas_out_o    (cas_o),
    .fold_o       (fold_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] p, input logic [4:0] m, input logic ce, input logic ci,
                       input logic [1:0] ps, input logic [2:0] xi, input logic [2:0] fi);
    @(negedge clk);
    pterm = p; mask = m; cas_en = ce; cas_in = ci; pol = ps; xidx = xi; fidx = fi;
    #1;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0;
    pterm = '0; mask = '0; cas_en = 1'b0; cas_in = 1'b0; pol = 2'b00; xidx = '0; fidx = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all inputs zero
    drive(5'b0, 5'b0, 1'b0, 1'b0, 2'b00, 3'd0, 3'd0);
    check("R1", "idle cas_out", cas_o, 1'b0);
    check("R4", "idle sum", sum_o, 1'b0);
    check("R8", "idle fold", fold_o, 1'b1);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][22:18], VEC[v][17:13], VEC[v][12], VEC[v][11], VEC[v][10:9],
            VEC[v][8:6], VEC[v][5:3]);
      check("R1-vec", "cas_out", cas_o, VEC[v][1]);
      check("R4-vec", "sum", sum_o, VEC[v][2]);
      check("R8-vec", "fold", fold_o, VEC[v][0]);
    end

    // R3: cascade out stable across every select code and XOR index
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < 8; x++) begin
        drive(5'b00100, 5'b00100, 1'b0, 1'b0, 2'(s), 3'(x), 3'd0);
        check("R3", "cas_out vs pol", cas_o, 1'b1);
      end
    end

    // R8 R9: fold sweep over all index codes
    for (int f = 0; f < 8; f++) begin
      logic [4:0] pat;
      pat = 5'b01101;
      drive(pat, 5'b11111, 1'b0, 1'b0, 2'b00, 3'd0, 3'(f));
      check((f < 5) ? "R8" : "R9", "fold sweep", fold_o, (f < 5) ? ~pat[f] : 1'b1);
    end

    // R6 R9: term-mode XOR index sweep with sum=0
    for (int x = 0; x < 8; x++) begin
      logic [4:0] pat;
      pat = 5'b10110;
      drive(pat, 5'b00000, 1'b0, 1'b0, 2'b10, 3'(x), 3'd0);
      check((x < 5) ? "R6" : "R9", "xor sweep", sum_o, (x < 5) ? pat[x] : 1'b0);
    end

    // R2: cas_in toggle ignored when disabled
    drive(5'b00000, 5'b00000, 1'b0, 1'b1, 2'b01, 3'd0, 3'd0);
    check("R2", "cas_in off cas_out", cas_o, 1'b0);
    check("R2", "cas_in off sum", sum_o, 1'b1);
    // R5: all terms allocated and high, inverted
    drive(5'b11111, 5'b11111, 1'b0, 1'b0, 2'b01, 3'd0, 3'd0);
    check("R5", "full sum inverted", sum_o, 1'b0);
    // R7: reserved code ignores term operand
    drive(5'b00001, 5'b00000, 1'b0, 1'b0, 2'b11, 3'd0, 3'd0);
    check("R7", "reserved sum", sum_o, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule